// File: doc/BRIEF.md
# DRAM Reset and Clock-Enable Initialiser

This block takes registered memory modules out of reset once software has configured the memory controller. Software does three things. It declares the memory clock stable with a clock-ratio-valid bit. It picks a memory speed with a 3-bit period-select code. It then raises an init-start bit. Until the clock-ratio-valid bit is set, the block keeps the module reset low and both clock enables low.

With both bits high, the block waits for a delay that depends on the selected speed. This gives the phase-locked loops in the module registers time to settle. The block then releases the active-low module reset. After that it counts memory-clock periods, which arrive as a one-cycle strobe per period. When the count is complete it raises the lower and upper clock-enable outputs together and sets a ready flag.

Dropping either software bit at any point aborts the sequence. The module reset goes low again and both clock enables and the ready flag fall. Wall-clock delays are formed from a core-cycles-per-microsecond parameter.

Top module: `dram_rst_cke_init`

## Requirements
- R1: After reset, mem_reset_n, cke_lo, cke_up and init_done are all 0.
- R2: While clk_ratio_valid is 0, mem_reset_n stays 0 even if init_start is 1. The sequence starts at the first clock edge that samples both bits as 1.
- R3: The reset-release delay D in microseconds follows mclk_sel. Code 0 (100 MHz) gives 655, code 1 (133 MHz) gives 524, and codes 2 (166 MHz) and 3 (200 MHz) give 394. mem_reset_n rises at the edge that comes 1 + D*CYC_PER_US edges after the last edge at which either bit was still low.
- R4: Codes 4 to 7 use the longest delay, 655 microseconds.
- R5: cke_lo and cke_up rise at the edge that samples the CKE_TICKS-th (default 12) mclk_tick high after mem_reset_n rose. A tick sampled at the release edge itself is not counted.
- R6: cke_lo and cke_up are always equal.
- R7: init_done rises in the same cycle as the clock enables and equals them.
- R8: If either bit is 0 during the delay, then from the next edge mem_reset_n is 0 and the sequence restarts only when both bits are high again.
- R9: If either bit is 0 after completion, then from the next edge mem_reset_n, both clock enables and init_done are 0.
- R10: Once complete, the outputs hold (mem_reset_n, cke and init_done all 1) while both bits stay 1.
- R11: The clock enables are never high while mem_reset_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ratio_valid | input | 1 | Software flag: memory clock stable |
| mclk_sel | input | 3 | Memory clock period select code |
| init_start | input | 1 | Software flag: start initialisation |
| mclk_tick | input | 1 | One-cycle strobe per memory-clock period |
| mem_reset_n | output | 1 | Active-low reset to the memory modules |
| cke_lo | output | 1 | Clock enable, lower channel |
| cke_up | output | 1 | Clock enable, upper channel |
| init_done | output | 1 | Initialisation complete |

## Verification
The reset release is due exactly 1 + D*CYC_PER_US edges after the driver raises the start bits. The driver records that edge count and pushes the expected latency into a queue. The monitor pops it when it sees mem_reset_n rise and compares the measured edge count against it. The clock-enable rise is due on the edge that samples the twelfth tick after release, so the monitor counts the ticks seen at each edge from the release onward. Abort effects are due one edge after a bit drops, and the bench samples them shortly after that edge.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WRST = 2'd1,
    ST_WCKE = 2'd2,
    ST_DONE = 2'd3
  } seq_st_e;
endpackage

// File: rtl/dram_init_delay_lut.sv
module dram_init_delay_lut #(
  parameter int DW      = 10,
  parameter int SLOW_US = 655,
  parameter int MID_US  = 524,
  parameter int FAST_US = 394
) (
  input  logic [2:0]    sel,
  output logic [DW-1:0] delay_us
);
  always_comb begin
    case (sel)
      3'd0:    delay_us = DW'(SLOW_US);
      3'd1:    delay_us = DW'(MID_US);
      3'd2:    delay_us = DW'(FAST_US);
      3'd3:    delay_us = DW'(FAST_US);
      default: delay_us = DW'(SLOW_US);
    endcase
  end
endmodule

// File: rtl/dram_init_counter.sv
module dram_init_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign hit = en && !clr && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || hit) cnt_d = '0;
    else if (en)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en) |-> (cnt_q <= limit));
endmodule

// File: rtl/dram_rst_cke_init.sv
module dram_rst_cke_init
  import dram_init_pkg::*;
#(
  parameter int CYC_PER_US = 200,
  parameter int CKE_TICKS  = 12,
  parameter int SLOW_US    = 655,
  parameter int MID_US     = 524,
  parameter int FAST_US    = 394
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_ratio_valid,
  input  logic [2:0] mclk_sel,
  input  logic       init_start,
  input  logic       mclk_tick,
  output logic       mem_reset_n,
  output logic       cke_lo,
  output logic       cke_up,
  output logic       init_done
);
  localparam int DW = $clog2(SLOW_US + 1);
  localparam int PW = $clog2(CYC_PER_US + 1);
  localparam int TW = $clog2(CKE_TICKS + 1);
  localparam logic [PW-1:0] PRE_LIM = PW'(CYC_PER_US - 1);
  localparam logic [TW-1:0] TCK_LIM = TW'(CKE_TICKS - 1);

  seq_st_e       st_q, st_d;
  logic [DW-1:0] lut_us, dly_q, dly_d;
  logic          go, idle, us_strobe, release_hit, cke_hit;

  assign go   = clk_ratio_valid && init_start;
  assign idle = (st_q == ST_IDLE);

  dram_init_delay_lut #(
    .DW(DW), .SLOW_US(SLOW_US), .MID_US(MID_US), .FAST_US(FAST_US)
  ) u_lut (
    .sel(mclk_sel), .delay_us(lut_us)
  );

  dram_init_counter #(.CW(PW)) u_prescale (
    .clk(clk), .rst_n(rst_n), .clr(idle),
    .en(st_q == ST_WRST), .limit(PRE_LIM), .hit(us_strobe)
  );

  dram_init_counter #(.CW(DW)) u_us_cnt (
    .clk(clk), .rst_n(rst_n), .clr(idle),
    .en(us_strobe), .limit(dly_q - 1'b1), .hit(release_hit)
  );

  dram_init_counter #(.CW(TW)) u_tick_cnt (
    .clk(clk), .rst_n(rst_n), .clr(idle),
    .en((st_q == ST_WCKE) && mclk_tick), .limit(TCK_LIM), .hit(cke_hit)
  );

  always_comb begin
    st_d  = st_q;
    dly_d = dly_q;
    if (!go) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_d  = ST_WRST;
          dly_d = lut_us;
        end
        ST_WRST: if (release_hit) st_d = ST_WCKE;
        ST_WCKE: if (cke_hit)     st_d = ST_DONE;
        default: st_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dly_q <= DW'(SLOW_US);
    end else begin
      st_q  <= st_d;
      dly_q <= dly_d;
    end
  end

  assign mem_reset_n = (st_q == ST_WCKE) || (st_q == ST_DONE);
  assign cke_lo      = (st_q == ST_DONE);
  assign cke_up      = (st_q == ST_DONE);
  assign init_done   = (st_q == ST_DONE);

  a_r2_hold_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_ratio_valid |=> !mem_reset_n);
  a_r3_release_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_reset_n) |-> $past(go));
  a_r6_cke_match: assert property (@(posedge clk) disable iff (!rst_n)
    cke_lo == cke_up);
  a_r7_done_with_cke: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $rose(cke_lo));
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (!mem_reset_n && !cke_lo && !init_done));
  a_r11_cke_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    cke_up |-> mem_reset_n);
endmodule

// File: tb/dram_rst_cke_init_bench.sv
module dram_rst_cke_init_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int NTICK      = 12;

  logic clk = 1'b0;
  logic rst_n, valid, init, tick;
  logic [2:0] sel;
  logic rstn_o, ckl, cku, done;

  int tests = 0, fails = 0, cyc = 0, start_cyc = 0, tcnt = 0;
  bit finished = 0;
  int exp_q[$];
  logic prev_r, prev_c;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_rst_cke_init #(.CYC_PER_US(CPU), .CKE_TICKS(NTICK)) u_dram_rst_cke_init (
    .clk(clk), .rst_n(rst_n), .clk_ratio_valid(valid), .mclk_sel(sel),
    .init_start(init), .mclk_tick(tick), .mem_reset_n(rstn_o),
    .cke_lo(ckl), .cke_up(cku), .init_done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dly_of(input logic [2:0] s);
    case (s)
      3'd1: return 524;
      3'd2, 3'd3: return 394;
      default: return 655;
    endcase
  endfunction

  initial begin
    tick = 1'b0;
    forever begin
      repeat (2) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // monitor: scoreboard on release, tick count on cke rise
  initial begin
    prev_r = 1'b0; prev_c = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (rst_n) begin
        if (prev_r && !prev_c && tick) tcnt++;
        if (!prev_r && rstn_o) begin
          tcnt = 0;
          if (exp_q.size() == 0) chk("R8 unexpected release", 1, 0);
          else chk("R3/R4 release latency", cyc - start_cyc, exp_q.pop_front());
        end
        if (!prev_c && ckl) begin
          chk("R5 ticks before cke", tcnt, NTICK);
          chk("R7 done with cke", int'(done), 1);
          chk("R6 cke_up matches", int'(cku), 1);
        end
      end
      prev_r = rstn_o; prev_c = ckl;
    end
  end

  task automatic run_seq(input logic [2:0] s);
    @(negedge clk);
    sel = s; init = 1'b1; valid = 1'b1;
    start_cyc = cyc;
    exp_q.push_back(1 + dly_of(s) * CPU);
    while (!done) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R10 done holds", int'(done && ckl && cku && rstn_o), 1);
    init = 1'b0;
    @(posedge clk); #1;
    chk("R9 abort after done", int'({rstn_o, ckl, cku, done}), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; init = 1'b0; sel = 3'd0;
    repeat (3) @(posedge clk); #1;
    chk("R1 reset state", int'({rstn_o, ckl, cku, done}), 0);
    @(negedge clk); rst_n = 1'b1;
    // R2: init without valid
    @(negedge clk); init = 1'b1; sel = 3'd2;
    repeat (60) @(posedge clk); #1;
    chk("R2 no release without valid", int'(rstn_o), 0);
    @(negedge clk); valid = 1'b1; start_cyc = cyc;
    exp_q.push_back(1 + 394 * CPU);
    while (!done) @(negedge clk);
    init = 1'b0; valid = 1'b0;
    repeat (3) @(negedge clk);
    run_seq(3'd0);
    run_seq(3'd1);
    run_seq(3'd3);
    run_seq(3'd7);
    run_seq(3'd5);
    // R8: abort by init during delay
    @(negedge clk); sel = 3'd0; valid = 1'b1; init = 1'b1;
    repeat (100) @(negedge clk);
    init = 1'b0;
    @(posedge clk); #1;
    chk("R8 abort via init", int'({rstn_o, ckl, done}), 0);
    repeat (1400) @(negedge clk);
    chk("R8 stays in reset", int'(rstn_o), 0);
    // R8: abort by valid, then restart
    init = 1'b1; sel = 3'd2;
    repeat (300) @(negedge clk);
    valid = 1'b0;
    @(posedge clk); #1;
    chk("R8 abort via valid", int'(rstn_o), 0);
    @(negedge clk); valid = 1'b1; start_cyc = cyc;
    exp_q.push_back(1 + 394 * CPU);
    while (!done) @(negedge clk);
    chk("R8 restart completes", int'(done), 1);
    chk("R3 queue drained", exp_q.size(), 0);
    summary();
  end
endmodule